// File: doc/BRIEF.md
# Set-Associative Read Cache Lookup and Miss Controller

This block sits between a processor pipeline and the on-chip bus. It serves word reads from an N-way set-associative cache whose tag, context, valid and data arrays are kept in registers. Every access reads all ways of the addressed set at once and compares them. A hit returns the word combinationally in the same cycle, so the pipeline can issue one read per cycle without stalling.

On a miss the data output in the request cycle carries no meaning. From the next cycle on, `hold_o` freezes the pipeline while the whole line is fetched as a burst of sequential word beats. When the last beat has arrived, the requested word is presented for one cycle with the strobe `mds_o`, and hold drops in the cycle after that. Lines from cacheable addresses are written into the set. An invalid way is chosen first; otherwise a per-set round-robin pointer picks the victim. A flush input invalidates the whole cache at a rate of one set per cycle.

Top module: `cache_ctrl`

## Requirements
- R1: A request to a line held in a valid way raises `hit_o` in the request cycle, with `rd_data_o` equal to the addressed word. `hold_o` stays low. Before any fill, no request hits.
- R2: Consecutive hit requests are each served in their own cycle, with no hold cycle between them.
- R3: A missing request has `hit_o` low in its cycle. From the next cycle, `hold_o` and `bus_req_o` are high, and `bus_addr_o` is the line base address (low log2(line bytes) bits zero, upper bits from the request). The address stays stable while the request is up.
- R4: The line arrives as LINE_WORDS beats on `bus_rvalid_i`, in word order from offset 0. Idle cycles may occur between beats. The cycle after the last beat has `mds_o` high for exactly one cycle, with `rd_data_o` equal to the requested word and `hold_o` still high. `hold_o` is low in the following cycle.
- R5: After a cacheable miss, any word of that line hits.
- R6: A miss with `req_cacheable_i` low is not stored, so repeating it misses again.
- R7: With `mmu_en_i` high, a hit also needs `ctx_i` to equal the context recorded at fill. With `mmu_en_i` low, the context is ignored.
- R8: A fill takes the lowest-numbered invalid way. When all ways are valid, it takes the way named by the set's round-robin pointer. The pointer starts at way 0 and moves to the way after the one just replaced.
- R9: `flush_i` in an idle cycle takes priority over a request in the same cycle: `hit_o` stays low and no miss starts. `hold_o` is then high for exactly SETS cycles, after which every line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Read request, ignored while hold is high |
| req_addr_i | input | ADDR_W | Byte address of the requested word |
| req_cacheable_i | input | 1 | Store the line if the request misses |
| mmu_en_i | input | 1 | Include context in the hit test |
| ctx_i | input | CTX_W | Context of the request |
| flush_i | input | 1 | Invalidate all lines |
| hit_o | output | 1 | Request hit this cycle |
| rd_data_o | output | WORD_W | Read data on hit or strobe |
| hold_o | output | 1 | Freeze the pipeline |
| mds_o | output | 1 | Miss data strobe |
| bus_req_o | output | 1 | Line fetch in progress |
| bus_addr_o | output | ADDR_W | Line base address |
| bus_rvalid_i | input | 1 | Beat valid |
| bus_rdata_i | input | WORD_W | Beat data |

## Verification
A hit result is due combinationally in the request cycle. The bench drives inputs at the falling edge and reads `hit_o` and `rd_data_o` two nanoseconds later in that same cycle. A miss owes `hold_o` and `bus_req_o` one cycle after the request, the strobe one cycle after the last beat, and a low hold one cycle after the strobe. The monitor therefore arms a check for the next sample after each of these events, and does not wait for an arbitrary delay. A flush owes exactly SETS hold cycles, which the bench counts at every falling edge.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STRB  = 2'd2,
    ST_FLUSH = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int WAYS       = 4,
  parameter int TAG_W      = 21,
  parameter int CTX_W      = 8,
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 32,
  parameter int WOFF_W     = 3
) (
  input  logic [WAYS-1:0]                               set_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]                    set_tags,
  input  logic [WAYS-1:0][CTX_W-1:0]                    set_ctx,
  input  logic [WAYS-1:0][LINE_WORDS-1:0][WORD_W-1:0]   set_data,
  input  logic [TAG_W-1:0]                              req_tag,
  input  logic [CTX_W-1:0]                              req_ctx,
  input  logic                                          mmu_en,
  input  logic [WOFF_W-1:0]                             word_off,
  output logic [WAYS-1:0]                               way_hit,
  output logic                                          any_hit,
  output logic [WORD_W-1:0]                             hit_word
);
  // one comparator per way, all in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = set_valid[w] && (set_tags[w] == req_tag) &&
                        (!mmu_en || (set_ctx[w] == req_ctx));
  end

  assign any_hit = |way_hit;

  // AND-OR selection of the matching way's word
  always_comb begin
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_word = hit_word | set_data[w][word_off];
    end
  end
endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim,
  output logic             use_rr
);
  // lowest invalid way wins; otherwise the round-robin pointer
  always_comb begin
    victim = rr_ptr;
    use_rr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        victim = WAY_W'(w);
        use_rr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 8,
  parameter int CTX_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_cacheable_i,
  input  logic              mmu_en_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic              flush_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              hold_o,
  output logic              mds_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_rvalid_i,
  input  logic [WORD_W-1:0] bus_rdata_i
);
  import cache_pkg::*;

  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WOFF_W   = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
  localparam int IDX_W    = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int LINE_OFF = BYTE_OFF + WOFF_W;
  localparam int TAG_W    = ADDR_W - LINE_OFF - IDX_W;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[LINE_OFF +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WOFF_W-1:0] woff_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF +: WOFF_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}};
  endfunction

  function automatic logic [WAY_W-1:0] rr_next(input logic [WAY_W-1:0] v);
    return (v == WAY_W'(WAYS - 1)) ? '0 : v + 1'b1;
  endfunction

  // storage
  logic [WAYS-1:0]                             valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]                  tag_q   [SETS];
  logic [WAYS-1:0][CTX_W-1:0]                  ctx_q   [SETS];
  logic [WAYS-1:0][LINE_WORDS-1:0][WORD_W-1:0] data_q  [SETS];
  logic [WAY_W-1:0]                            rr_q    [SETS];

  // control state
  cache_state_e      state_q;
  logic [ADDR_W-1:0] m_addr_q;
  logic              m_cache_q;
  logic [CTX_W-1:0]  m_ctx_q;
  logic [WAY_W-1:0]  m_vict_q;
  logic              m_userr_q;
  logic [WOFF_W-1:0] beat_q;
  logic [WORD_W-1:0] m_word_q;
  logic [IDX_W-1:0]  fl_set_q;

  // named internal events
  logic              idle;
  logic              accept;
  logic              miss_evt;
  logic              flush_start;
  logic              beat_take;
  logic              fill_last;
  logic [IDX_W-1:0]  req_idx;
  logic [IDX_W-1:0]  m_idx;
  logic [WAYS-1:0]   way_hit;
  logic              any_hit;
  logic [WORD_W-1:0] hit_word;
  logic [WAY_W-1:0]  victim;
  logic              use_rr;

  assign req_idx = idx_of(req_addr_i);
  assign m_idx   = idx_of(m_addr_q);

  cache_lookup #(
    .WAYS(WAYS), .TAG_W(TAG_W), .CTX_W(CTX_W),
    .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W), .WOFF_W(WOFF_W)
  ) lookup_i (
    .set_valid (valid_q[req_idx]),
    .set_tags  (tag_q[req_idx]),
    .set_ctx   (ctx_q[req_idx]),
    .set_data  (data_q[req_idx]),
    .req_tag   (tag_of(req_addr_i)),
    .req_ctx   (ctx_i),
    .mmu_en    (mmu_en_i),
    .word_off  (woff_of(req_addr_i)),
    .way_hit   (way_hit),
    .any_hit   (any_hit),
    .hit_word  (hit_word)
  );

  cache_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) victim_i (
    .set_valid (valid_q[req_idx]),
    .rr_ptr    (rr_q[req_idx]),
    .victim    (victim),
    .use_rr    (use_rr)
  );

  assign idle        = (state_q == ST_IDLE);
  assign flush_start = idle && flush_i;
  assign accept      = idle && req_valid_i && !flush_i;
  assign hit_o       = accept && any_hit;
  assign miss_evt    = accept && !any_hit;
  assign beat_take   = (state_q == ST_FETCH) && bus_rvalid_i;
  assign fill_last   = beat_take && (beat_q == WOFF_W'(LINE_WORDS - 1));

  assign hold_o      = !idle;
  assign mds_o       = (state_q == ST_STRB);
  assign rd_data_o   = mds_o ? m_word_q : hit_word;
  assign bus_req_o   = (state_q == ST_FETCH);
  assign bus_addr_o  = line_base(m_addr_q);

  // control, valid bits and replacement pointers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      m_addr_q  <= '0;
      m_cache_q <= 1'b0;
      m_ctx_q   <= '0;
      m_vict_q  <= '0;
      m_userr_q <= 1'b0;
      beat_q    <= '0;
      m_word_q  <= '0;
      fl_set_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (flush_start) begin
            state_q  <= ST_FLUSH;
            fl_set_q <= '0;
          end else if (miss_evt) begin
            state_q   <= ST_FETCH;
            m_addr_q  <= req_addr_i;
            m_cache_q <= req_cacheable_i;
            m_ctx_q   <= ctx_i;
            m_vict_q  <= victim;
            m_userr_q <= use_rr;
            beat_q    <= '0;
          end
        end
        ST_FETCH: begin
          if (beat_take) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == woff_of(m_addr_q)) m_word_q <= bus_rdata_i;
          end
          if (fill_last) begin
            state_q <= ST_STRB;
            if (m_cache_q) begin
              valid_q[m_idx][m_vict_q] <= 1'b1;
              if (m_userr_q) rr_q[m_idx] <= rr_next(m_vict_q);
            end
          end
        end
        ST_STRB: state_q <= ST_IDLE;
        ST_FLUSH: begin
          valid_q[fl_set_q] <= '0;
          rr_q[fl_set_q]    <= '0;
          if (fl_set_q == IDX_W'(SETS - 1)) state_q <= ST_IDLE;
          else fl_set_q <= fl_set_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // tag, context and data arrays: written only by fills, no reset needed
  always_ff @(posedge clk) begin
    if (beat_take && m_cache_q) data_q[m_idx][m_vict_q][beat_q] <= bus_rdata_i;
    if (fill_last && m_cache_q) begin
      tag_q[m_idx][m_vict_q] <= tag_of(m_addr_q);
      ctx_q[m_idx][m_vict_q] <= m_ctx_q;
    end
  end
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              flush_i,
  input logic              hit_o,
  input logic              hold_o,
  input logic              mds_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              miss_evt,
  input logic              fill_last
);
  assert_hit_unstalled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (req_valid_i && !hold_o));

  assert_results_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_o, mds_o, bus_req_o}));

  assert_hold_after_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (hold_o && bus_req_o));

  assert_bus_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && $past(bus_req_o)) |-> $stable(bus_addr_o));

  assert_strobe_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> mds_o);

  assert_strobe_under_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mds_o |-> hold_o);

  assert_release_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mds_o |=> (!hold_o && !mds_o));

  assert_flush_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !hold_o) |=> (hold_o && !bus_req_o));
endmodule

bind cache_ctrl cache_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .flush_i     (flush_i),
  .hit_o       (hit_o),
  .hold_o      (hold_o),
  .mds_o       (mds_o),
  .bus_req_o   (bus_req_o),
  .bus_addr_o  (bus_addr_o),
  .miss_evt    (miss_evt),
  .fill_last   (fill_last)
);

// File: tb/cache_ctrl_tb.sv
module cache_ctrl_tb_top;
  localparam int SETS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_cacheable_i = 1'b0;
  logic        mmu_en_i = 1'b0;
  logic [7:0]  ctx_i = '0;
  logic        flush_i = 1'b0;
  logic        hit_o;
  logic [31:0] rd_data_o;
  logic        hold_o;
  logic        mds_o;
  logic        bus_req_o;
  logic [31:0] bus_addr_o;
  logic        bus_rvalid_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;

  always #4 clk = ~clk; // 125 MHz

  cache_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_cacheable_i(req_cacheable_i), .mmu_en_i(mmu_en_i), .ctx_i(ctx_i),
    .flush_i(flush_i), .hit_o(hit_o), .rd_data_o(rd_data_o), .hold_o(hold_o),
    .mds_o(mds_o), .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o),
    .bus_rvalid_i(bus_rvalid_i), .bus_rdata_i(bus_rdata_i)
  );

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [31:0] addr;
    bit          exp_hit;
    string       rtag;
  } item_t;

  item_t exp_q[$];
  item_t pend;
  bit    pend_ok = 1'b0;
  bit    chk_hold_next = 1'b0;
  bit    chk_release = 1'b0;

  // backing memory pattern, independent of the design
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0F1E;
  endfunction

  task automatic check(input bit ok, input string rtag, input logic [31:0] act,
                       input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", rtag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // bus responder: two-cycle latency, one idle gap before beat 3
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req_o) begin
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          if (i == 3) begin
            bus_rvalid_i = 1'b0;
            @(negedge clk);
          end
          bus_rvalid_i = 1'b1;
          bus_rdata_i  = mem_word(bus_addr_o + 32'(4 * i));
          @(negedge clk);
        end
        bus_rvalid_i = 1'b0;
      end
    end
  end

  // monitor: compares design results with queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (chk_hold_next) begin
        chk_hold_next = 1'b0;
        check(hold_o && bus_req_o, "R3 hold/bus_req after miss", {30'd0, hold_o, bus_req_o}, 32'h3);
        check(bus_addr_o == {pend.addr[31:5], 5'd0}, "R3 line base", bus_addr_o,
              {pend.addr[31:5], 5'd0});
      end
      if (chk_release) begin
        chk_release = 1'b0;
        check(!hold_o && !mds_o, "R4 release after strobe", {30'd0, hold_o, mds_o}, 32'h0);
      end
      if (mds_o) begin
        check(pend_ok, "R4 strobe without miss", 32'(pend_ok), 32'd1);
        check(hold_o, "R4 hold during strobe", 32'(hold_o), 32'd1);
        check(rd_data_o == mem_word(pend.addr), {"R4 miss data ", pend.rtag}, rd_data_o,
              mem_word(pend.addr));
        pend_ok = 1'b0;
        chk_release = 1'b1;
      end
      if (req_valid_i && !hold_o && !flush_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected request", 32'd0, 32'd1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(hit_o == it.exp_hit, {it.rtag, " hit flag"}, 32'(hit_o), 32'(it.exp_hit));
          if (it.exp_hit) begin
            check(rd_data_o == mem_word(it.addr), {it.rtag, " hit data"}, rd_data_o,
                  mem_word(it.addr));
          end else begin
            pend = it;
            pend_ok = 1'b1;
            chk_hold_next = 1'b1;
          end
        end
      end
    end
  end

  // driver: one access, waits until the pipeline is released
  task automatic access(input logic [31:0] addr, input bit cch, input bit mmu,
                        input logic [7:0] ctx, input bit exp_hit, input string rtag);
    item_t it;
    @(negedge clk);
    req_addr_i = addr;
    req_cacheable_i = cch;
    mmu_en_i = mmu;
    ctx_i = ctx;
    req_valid_i = 1'b1;
    it.addr = addr;
    it.exp_hit = exp_hit;
    it.rtag = rtag;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid_i = 1'b0;
    while (hold_o) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state (R1: nothing hits, no hold)
    check(!hold_o && !mds_o && !bus_req_o, "R1 reset state",
          {29'd0, hold_o, mds_o, bus_req_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5: cacheable miss then hits in the same line
    access(32'h0000_0104, 1, 0, 8'd0, 0, "R3");
    access(32'h0000_0104, 1, 0, 8'd0, 1, "R5");
    access(32'h0000_011C, 1, 0, 8'd0, 1, "R1");

    // R2: four back-to-back hits, one per cycle
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      item_t it;
      req_addr_i = 32'h0000_0100 + 32'(8 * i);
      req_cacheable_i = 1'b1;
      mmu_en_i = 1'b0;
      req_valid_i = 1'b1;
      it.addr = req_addr_i;
      it.exp_hit = 1'b1;
      it.rtag = "R2";
      exp_q.push_back(it);
      #1;
      check(!hold_o, "R2 no stall in burst", 32'(hold_o), 32'd0);
      @(negedge clk);
    end
    req_valid_i = 1'b0;

    // R6: non-cacheable miss is not stored
    access(32'h0004_0204, 0, 0, 8'd0, 0, "R6");
    access(32'h0004_0204, 0, 0, 8'd0, 0, "R6");

    // R7: context match under MMU enable
    access(32'h0008_0300, 1, 1, 8'd3, 0, "R7");
    access(32'h0008_0300, 1, 1, 8'd3, 1, "R7");
    access(32'h0008_0300, 0, 1, 8'd4, 0, "R7");
    access(32'h0008_0300, 1, 0, 8'd9, 1, "R7");

    // R8: set 0, invalid ways first, then round robin
    for (int k = 1; k <= 4; k++) access(32'(k * 32'h800 + 32'hC), 1, 0, 8'd0, 0, "R8");
    for (int k = 1; k <= 4; k++) access(32'(k * 32'h800 + 32'hC), 1, 0, 8'd0, 1, "R8");
    access(32'h0000_280C, 1, 0, 8'd0, 0, "R8");  // k=5 evicts way 0 (k=1)
    access(32'h0000_100C, 1, 0, 8'd0, 1, "R8");  // k=2 still present
    access(32'h0000_080C, 1, 0, 8'd0, 0, "R8");  // k=1 gone, evicts way 1 (k=2)
    access(32'h0000_100C, 1, 0, 8'd0, 0, "R8");  // k=2 gone, evicts way 2 (k=3)
    access(32'h0000_200C, 1, 0, 8'd0, 1, "R8");  // k=4
    access(32'h0000_280C, 1, 0, 8'd0, 1, "R8");  // k=5
    access(32'h0000_080C, 1, 0, 8'd0, 1, "R8");  // k=1
    access(32'h0000_180C, 1, 0, 8'd0, 0, "R8");  // k=3 gone

    // R9: flush with a concurrent request to a cached line
    @(negedge clk);
    flush_i = 1'b1;
    req_valid_i = 1'b1;
    req_addr_i = 32'h0000_0104;
    req_cacheable_i = 1'b1;
    #2;
    check(!hit_o, "R9 flush beats request", 32'(hit_o), 32'd0);
    @(negedge clk);
    flush_i = 1'b0;
    req_valid_i = 1'b0;
    begin
      int n;
      n = 0;
      while (hold_o) begin
        check(!bus_req_o, "R9 no fetch during flush", 32'(bus_req_o), 32'd0);
        n++;
        @(negedge clk);
      end
      check(n == SETS, "R9 flush cycles", 32'(n), 32'(SETS));
    end
    access(32'h0000_0104, 1, 0, 8'd0, 0, "R9");
    access(32'h0008_0300, 1, 0, 8'd0, 0, "R9");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !pend_ok, "R1 all results seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule